// File: doc/BRIEF.md
# Posted Write Error Tracker

This block keeps track of physical writes that the link side has already answered with a complete acknowledge, while the data still has to reach host memory. Each incoming physical write asks for a slot. While a slot is free, the write is posted: it gets a complete acknowledge and a slot index, and it stays pending until the memory engine reports on that slot. Once every slot is taken, a new write is not posted. It gets a pending acknowledge, and the memory engine reports its completion through its own path.

A write that fails on the host bus keeps its slot and joins a queue of failures, held in the order they happened. Software sees these failures one at a time through one error flag and two read-only address words. It reads the words and then clears the flag. The clear frees the slot of the reported write. After the flag has stayed low for a cycle, the next queued failure is shown.

Top module: `pw_err_tracker`

## Requirements
- R1: After reset, err_flag, resp_valid, addr_word0 and addr_word1 are all 0 and all four slots are free.
- R2: A request arriving while fewer than four writes are pending is posted. In the next cycle resp_valid=1 and resp_posted=1 (complete acknowledge), and resp_slot holds the lowest-numbered free slot.
- R3: A request arriving while four writes are pending gets resp_valid=1 and resp_posted=0 (pending acknowledge) in the next cycle, and it takes no slot.
- R4: A done strobe on a pending, non-failed slot frees that slot at once, so the next request can be posted into it.
- R5: A fail strobe on a pending slot keeps that slot occupied. If no failure is being shown, err_flag rises two clock edges after the strobe is sampled.
- R6: While err_flag is high, addr_word0 holds the failing write's source ID in bits [31:16] and offset bits [47:32] in bits [15:0]. addr_word1 holds offset bits [31:0].
- R7: A software clear while err_flag is high frees the slot of the write being shown.
- R8: Queued failures are shown in the order their fail strobes arrived.
- R9: After a clear, err_flag stays low for at least one cycle before another failure is shown.
- R10: A clear while err_flag is low, and a done strobe on a slot whose write has failed, have no effect. The address words, the flag and slot occupancy stay unchanged.
- R11: A new failure arriving while another is shown does not change the address words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New physical write request |
| req_src | input | 16 | Source node ID of the request |
| req_offset | input | 48 | Destination offset of the request |
| done_valid | input | 1 | Memory write finished without error |
| done_slot | input | 2 | Slot of the finished write |
| fail_valid | input | 1 | Memory write failed on the host bus |
| fail_slot | input | 2 | Slot of the failed write |
| sw_clr | input | 1 | Software clear of the error flag |
| resp_valid | output | 1 | Acknowledge decision valid |
| resp_posted | output | 1 | 1 = complete acknowledge (posted), 0 = pending acknowledge |
| resp_slot | output | 2 | Slot given to a posted write |
| err_flag | output | 1 | Posted-write error event bit |
| addr_word0 | output | 32 | {source ID, offset[47:32]} of the shown failure |
| addr_word1 | output | 32 | offset[31:0] of the shown failure |

## Verification
The bench fills all four slots and checks that the fifth request is answered as pending without taking a slot. A tracker that posted a fifth write, or let the pending request take a slot, would show up when a freed slot is handed out twice. It holds two failures at once and checks the clear handshake. The second failure must not overwrite the words on view, must come out after the first, and must appear only after the flag has dropped for a cycle. It also sends a done strobe to a failed slot. A design that honoured that strobe would free a slot still under report, and the next request would be posted where it should be answered as pending.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int SRC_W  = 16;
    localparam int OFF_W  = 48;
    localparam int WORD_W = 32;
    localparam int OFF_HI_W = OFF_W - WORD_W;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [OFF_W-1:0] off;
    } pw_entry_t;
endpackage

// File: rtl/pw_slot_table.sv
module pw_slot_table
    import pw_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [SRC_W-1:0] alloc_src,
    input  logic [OFF_W-1:0] alloc_off,
    input  logic             done_valid,
    input  logic [IDX_W-1:0] done_slot,
    input  logic             fail_valid,
    input  logic [IDX_W-1:0] fail_slot,
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_slot,
    input  logic [IDX_W-1:0] rd_slot,
    output logic             has_free,
    output logic [IDX_W-1:0] free_idx,
    output logic             fail_accept,
    output logic [SRC_W-1:0] rd_src,
    output logic [OFF_W-1:0] rd_off
);
    typedef struct packed {
        logic [SLOTS-1:0]            busy;
        logic [SLOTS-1:0]            failed;
        pw_entry_t [SLOTS-1:0]       ent;
    } tbl_t;

    tbl_t st_q, st_d;
    logic done_ok;

    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!st_q.busy[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        st_d        = st_q;
        fail_accept = fail_valid && st_q.busy[fail_slot] && !st_q.failed[fail_slot];
        done_ok     = done_valid && st_q.busy[done_slot] && !st_q.failed[done_slot]
                      && !(fail_accept && (fail_slot == done_slot));
        if (alloc_en && has_free) begin
            st_d.busy[free_idx]    = 1'b1;
            st_d.failed[free_idx]  = 1'b0;
            st_d.ent[free_idx].src = alloc_src;
            st_d.ent[free_idx].off = alloc_off;
        end
        if (done_ok) begin
            st_d.busy[done_slot] = 1'b0;
        end
        if (fail_accept) begin
            st_d.failed[fail_slot] = 1'b1;
        end
        if (rel_valid) begin
            st_d.busy[rel_slot]   = 1'b0;
            st_d.failed[rel_slot] = 1'b0;
        end
        rd_src = st_q.ent[rd_slot].src;
        rd_off = st_q.ent[rd_slot].off;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Only a failed, still pending slot may be released by the report window.
    assert_release_failed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (st_q.busy[rel_slot] && st_q.failed[rel_slot]));

    // A failed slot stays occupied until released.
    assert_failed_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.failed[fail_slot] && fail_valid && !(rel_valid && rel_slot == fail_slot))
        |=> st_q.busy[$past(fail_slot)]);
endmodule

// File: rtl/pw_fail_fifo.sv
module pw_fail_fifo #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             rd_en,
    output logic [IDX_W-1:0] head_idx,
    output logic             empty,
    output logic             full
);
    typedef struct packed {
        logic [PTR_W-1:0]            rd_ptr;
        logic [PTR_W-1:0]            wr_ptr;
        logic [CNT_W-1:0]            cnt;
        logic [DEPTH-1:0][IDX_W-1:0] mem;
    } fifo_t;

    fifo_t st_q, st_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_comb begin
        logic do_wr, do_rd;
        st_d     = st_q;
        empty    = (st_q.cnt == '0);
        full     = (st_q.cnt == CNT_W'(DEPTH));
        head_idx = st_q.mem[st_q.rd_ptr];
        do_wr    = wr_en && !full;
        do_rd    = rd_en && !empty;
        if (do_wr) begin
            st_d.mem[st_q.wr_ptr] = wr_idx;
            st_d.wr_ptr           = ptr_inc(st_q.wr_ptr);
        end
        if (do_rd) begin
            st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        end
        if (do_wr && !do_rd) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (do_rd && !do_wr) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Every slot can fail at most once, so the queue never overflows.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && full));

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && empty));
endmodule

// File: rtl/pw_err_window.sv
module pw_err_window
    import pw_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [SRC_W-1:0]  head_src,
    input  logic [OFF_W-1:0]  head_off,
    input  logic              sw_clr,
    output logic              pop,
    output logic              rel_valid,
    output logic [IDX_W-1:0]  rel_slot,
    output logic              err_flag,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1
);
    typedef struct packed {
        logic              err;
        logic [IDX_W-1:0]  shown;
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
    } win_t;

    win_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        pop       = !st_q.err && !fifo_empty;
        rel_valid = st_q.err && sw_clr;
        rel_slot  = st_q.shown;
        if (pop) begin
            st_d.err   = 1'b1;
            st_d.shown = head_idx;
            st_d.w0    = {head_src, head_off[OFF_W-1:WORD_W]};
            st_d.w1    = head_off[WORD_W-1:0];
        end else if (rel_valid) begin
            st_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_flag = st_q.err;
    assign word0    = st_q.w0;
    assign word1    = st_q.w1;

    assert_drop_after_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && sw_clr) |=> !err_flag);

    assert_words_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !sw_clr) |=> (err_flag && $stable(word0) && $stable(word1)));

    assert_show_queued_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && !fifo_empty) |=> err_flag);

    assert_clear_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && fifo_empty) |=> (!err_flag && $stable(word0) && $stable(word1)));
endmodule

// File: rtl/pw_err_tracker.sv
module pw_err_tracker
    import pw_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              done_valid,
    input  logic [IDX_W-1:0]  done_slot,
    input  logic              fail_valid,
    input  logic [IDX_W-1:0]  fail_slot,
    input  logic              sw_clr,
    output logic              resp_valid,
    output logic              resp_posted,
    output logic [IDX_W-1:0]  resp_slot,
    output logic              err_flag,
    output logic [WORD_W-1:0] addr_word0,
    output logic [WORD_W-1:0] addr_word1
);
    typedef struct packed {
        logic             valid;
        logic             posted;
        logic [IDX_W-1:0] slot;
    } resp_t;

    resp_t rsp_q, rsp_d;

    logic             has_free, fail_accept;
    logic [IDX_W-1:0] free_idx;
    logic             pop, rel_valid, fifo_empty, fifo_full;
    logic [IDX_W-1:0] rel_slot, head_idx;
    logic [SRC_W-1:0] head_src;
    logic [OFF_W-1:0] head_off;

    pw_slot_table #(.SLOTS(SLOTS)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (req_valid),
        .alloc_src  (req_src),
        .alloc_off  (req_offset),
        .done_valid (done_valid),
        .done_slot  (done_slot),
        .fail_valid (fail_valid),
        .fail_slot  (fail_slot),
        .rel_valid  (rel_valid),
        .rel_slot   (rel_slot),
        .rd_slot    (head_idx),
        .has_free   (has_free),
        .free_idx   (free_idx),
        .fail_accept(fail_accept),
        .rd_src     (head_src),
        .rd_off     (head_off)
    );

    pw_fail_fifo #(.DEPTH(SLOTS), .IDX_W(IDX_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fail_accept),
        .wr_idx  (fail_slot),
        .rd_en   (pop),
        .head_idx(head_idx),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    pw_err_window #(.IDX_W(IDX_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_empty(fifo_empty),
        .head_idx  (head_idx),
        .head_src  (head_src),
        .head_off  (head_off),
        .sw_clr    (sw_clr),
        .pop       (pop),
        .rel_valid (rel_valid),
        .rel_slot  (rel_slot),
        .err_flag  (err_flag),
        .word0     (addr_word0),
        .word1     (addr_word1)
    );

    always_comb begin
        rsp_d        = '0;
        rsp_d.valid  = req_valid;
        rsp_d.posted = req_valid && has_free;
        rsp_d.slot   = has_free ? free_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign resp_valid  = rsp_q.valid;
    assign resp_posted = rsp_q.posted;
    assign resp_slot   = rsp_q.slot;

    assert_pending_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !has_free) |=> (resp_valid && !resp_posted));

    assert_posted_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && has_free) |=> (resp_valid && resp_posted));

    assert_queue_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fail_accept);
endmodule

// File: tb/pw_err_tracker_tb.sv
module pw_err_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_src = '0;
    logic [47:0] req_offset = '0;
    logic        done_valid = 1'b0;
    logic [1:0]  done_slot = '0;
    logic        fail_valid = 1'b0;
    logic [1:0]  fail_slot = '0;
    logic        sw_clr = 1'b0;
    logic        resp_valid, resp_posted;
    logic [1:0]  resp_slot;
    logic        err_flag;
    logic [31:0] addr_word0, addr_word1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] exp_src [4];
    logic [47:0] exp_off [4];

    always #2.5 clk = ~clk;

    pw_err_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_offset(req_offset), .done_valid(done_valid), .done_slot(done_slot),
        .fail_valid(fail_valid), .fail_slot(fail_slot), .sw_clr(sw_clr),
        .resp_valid(resp_valid), .resp_posted(resp_posted), .resp_slot(resp_slot),
        .err_flag(err_flag), .addr_word0(addr_word0), .addr_word1(addr_word1)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_req(input logic [15:0] src, input logic [47:0] off,
                            input string req, input bit exp_posted,
                            input logic [1:0] exp_slot);
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "resp_valid", 64'(resp_valid), 64'd1);
        check(req, "resp_posted", 64'(resp_posted), 64'(exp_posted));
        if (exp_posted) begin
            check(req, "resp_slot", 64'(resp_slot), 64'(exp_slot));
            exp_src[exp_slot] = src;
            exp_off[exp_slot] = off;
        end
    endtask

    task automatic strobe_done(input logic [1:0] s);
        @(negedge clk); done_valid = 1'b1; done_slot = s;
        @(negedge clk); done_valid = 1'b0;
    endtask

    task automatic strobe_fail(input logic [1:0] s);
        @(negedge clk); fail_valid = 1'b1; fail_slot = s;
        @(negedge clk); fail_valid = 1'b0;
    endtask

    task automatic pulse_clr;
        @(negedge clk); sw_clr = 1'b1;
        @(negedge clk); sw_clr = 1'b0;
    endtask

    task automatic check_words(input string req, input logic [1:0] s);
        check(req, "addr_word0", 64'(addr_word0), 64'({exp_src[s], exp_off[s][47:32]}));
        check(req, "addr_word1", 64'(addr_word1), 64'(exp_off[s][31:0]));
    endtask

    task automatic t_reset;
        check("R1", "err_flag", 64'(err_flag), 64'd0);
        check("R1", "resp_valid", 64'(resp_valid), 64'd0);
        check("R1", "addr_word0", 64'(addr_word0), 64'd0);
        check("R1", "addr_word1", 64'(addr_word1), 64'd0);
    endtask

    task automatic t_fill_and_full;
        for (int i = 0; i < 4; i++) begin
            send_req(16'hA100 + 16'(i), 48'h1234_0000_0000 + 48'(i) * 48'h0001_0101_0010,
                     "R2", 1'b1, 2'(i));
        end
        send_req(16'hBEEF, 48'h0, "R3", 1'b0, 2'd0);
    endtask

    task automatic t_done_frees;
        strobe_done(2'd2);
        send_req(16'hC222, 48'hABCD_1111_2222, "R4", 1'b1, 2'd2);
        send_req(16'hBEEF, 48'h0, "R3", 1'b0, 2'd0);
    endtask

    task automatic t_two_failures;
        strobe_fail(2'd1);
        check("R5", "err_flag one edge after strobe", 64'(err_flag), 64'd0);
        @(negedge clk);
        check("R5", "err_flag", 64'(err_flag), 64'd1);
        check_words("R6", 2'd1);
        send_req(16'hBEEF, 48'h0, "R5", 1'b0, 2'd0);
        strobe_fail(2'd3);
        @(negedge clk);
        check_words("R11", 2'd1);
        pulse_clr();
        check("R9", "err_flag after clear", 64'(err_flag), 64'd0);
        @(negedge clk);
        check("R8", "err_flag second failure", 64'(err_flag), 64'd1);
        check_words("R8", 2'd3);
        send_req(16'hD111, 48'h7777_8888_9999, "R7", 1'b1, 2'd1);
        pulse_clr();
        check("R9", "err_flag after last clear", 64'(err_flag), 64'd0);
        send_req(16'hD333, 48'h0000_5555_6666, "R7", 1'b1, 2'd3);
    endtask

    task automatic t_ignored;
        logic [31:0] w0, w1;
        w0 = addr_word0; w1 = addr_word1;
        pulse_clr();
        @(negedge clk);
        check("R10", "err_flag idle clear", 64'(err_flag), 64'd0);
        check("R10", "addr_word0 idle clear", 64'(addr_word0), 64'(w0));
        check("R10", "addr_word1 idle clear", 64'(addr_word1), 64'(w1));
        send_req(16'hBEEF, 48'h0, "R10", 1'b0, 2'd0);
        strobe_fail(2'd0);
        @(negedge clk);
        check("R5", "err_flag slot0", 64'(err_flag), 64'd1);
        check_words("R6", 2'd0);
        strobe_done(2'd0);
        send_req(16'hBEEF, 48'h0, "R10", 1'b0, 2'd0);
        pulse_clr();
        send_req(16'hE000, 48'hFFFF_0000_0001, "R7", 1'b1, 2'd0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_full();
        t_done_frees();
        t_two_failures();
        t_ignored();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule